// File: doc/BRIEF.md
# Multi-Thread Time-Aware Gate Scheduler

This block drives the transmit gates of a small switch from a time-based schedule. One shared table of timeslots holds, for each slot, a duration in delta units, a bitmap of the egress ports it applies to, and a mask of the traffic classes whose gates stay closed during that slot. Up to `NT` execution threads each own a contiguous slice of that table. A thread walks from its entry address to its end index and then wraps back to its entry address, without end.

All threads share one programmed base time. Thread `i` begins only when the time-of-day input reaches the base time plus that thread's own entry offset, so the threads start at staggered points. A register holding the index of the last active thread decides which threads run. The host loads the table, the per-thread entries and the global settings through simple write strobes while the engine is stopped. It then issues a start command. A stop command halts every thread and opens all gates.

When two running threads select the same port in the same cycle, their closed masks are merged by OR and a collision flag is raised.

Top module: `gs_sched`

## Requirements
- R1: After a synchronous reset the gate vector is all zero (every gate open), and `sched_running`, `sched_armed`, `collide` and `load_err` are all 0.
- R2: A `start_cmd` while stopped makes `sched_armed` 1 from the next cycle. The engine moves to running (`sched_running` 1, `sched_armed` 0) on the first clock edge at which `tod` is at least the programmed base time.
- R3: Thread `i` starts on the first clock edge with `tick` high at which `tod` is at least the base time plus its entry offset. Until then it closes no gate.
- R4: A started thread occupies slot `k` for `delta[k]` ticks. It walks from its entry address to its end index inclusive, then returns to its entry address and repeats.
- R5: Bit `p*NTC+c` of `gate_closed` is 1 (gate closed) when a started thread's current slot has port bit `p` set and closed-mask bit `c` set. The vector follows the thread state one clock later.
- R6: Only threads `0` to `last` run. Higher-numbered threads never start, whatever their entries hold.
- R7: When two or more started threads have overlapping port bitmaps, the gate vector is the OR of their contributions and `collide` is 1, in the same cycle.
- R8: A `stop_cmd` clears `sched_running` and `sched_armed` at the next edge. Two edges later every gate is open and `collide` is 0.
- R9: A slot write whose delta is 0 or at least 2^19 is discarded, as is a thread write whose entry offset is 0. Either one sets the sticky `load_err`.
- R10: Table, thread and global writes are ignored while the engine is armed or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod | input | TOD_W | Time of day in delta units |
| tick | input | 1 | One delta unit has elapsed |
| start_cmd | input | 1 | Arm the engine |
| stop_cmd | input | 1 | Halt the engine (has priority) |
| tbl_we | input | 1 | Slot table write strobe |
| tbl_addr | input | AW | Slot index |
| tbl_delta | input | DW | Slot duration in delta units |
| tbl_ports | input | NP | Port bitmap of the slot |
| tbl_closed | input | NTC | Classes held closed in the slot |
| thr_we | input | 1 | Thread entry write strobe |
| thr_sel | input | TW | Thread number |
| thr_ep_delta | input | DW | Start offset from the base time |
| thr_ep_addr | input | AW | First slot of the thread |
| thr_end | input | AW | Last slot of the thread |
| glob_we | input | 1 | Global settings write strobe |
| glob_base | input | TOD_W | Schedule base time |
| glob_last | input | TW | Highest active thread number |
| gate_closed | output | NP*NTC | Closed gates, bit p*NTC+c |
| sched_running | output | 1 | Engine running |
| sched_armed | output | 1 | Engine waiting for the base time |
| collide | output | 1 | Threads overlap on a port |
| load_err | output | 1 | Sticky rejected-write flag |

## Verification
Four properties are checked on every cycle: a rise of running must follow an armed cycle, a stop must clear the status at once, two stopped cycles must leave every gate open, and a collision must trace back to at least two threads that were valid one cycle earlier. The sticky error flag is also checked each cycle. Whether a thread starts at the right edge, walks its slice in order with the right slot lengths, wraps correctly, and stays silent when it lies beyond the active count can only be shown by the scenarios. The bench compares every gate bit against a time-based model of each thread's slice. The same applies to rejected or blocked writes, which show up only as unchanged gate patterns later on.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } eng_state_t;

  // slot durations must stay below 2**SLOT_LIM_LOG2 delta units
  localparam int SLOT_LIM_LOG2 = 19;
endpackage

// File: rtl/gs_slot_table.sv
module gs_slot_table #(
  parameter int DEPTH    = 32,
  parameter int NP       = 5,
  parameter int NTC      = 8,
  parameter int DW       = 20,
  parameter int LIM_LOG2 = 19,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdelta,
  input  logic [NP-1:0]     wports,
  input  logic [NTC-1:0]    wclosed,
  output logic              wr_bad,
  output logic [DW-1:0]     delta_q  [DEPTH],
  output logic [NP-1:0]     ports_q  [DEPTH],
  output logic [NTC-1:0]    closed_q [DEPTH]
);
  logic delta_ok;

  assign delta_ok = (wdelta != '0) && ((wdelta >> LIM_LOG2) == '0);
  assign wr_bad   = we && !delta_ok;

  always_ff @(posedge clk) begin
    if (we && delta_ok) begin
      delta_q[waddr]  <= wdelta;
      ports_q[waddr]  <= wports;
      closed_q[waddr] <= wclosed;
    end
  end
endmodule

// File: rtl/gs_thread.sv
module gs_thread #(
  parameter int DEPTH  = 32,
  parameter int DW     = 20,
  parameter int TOD_W  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [TOD_W-1:0] tod,
  input  logic [TOD_W-1:0] start_at,
  input  logic [AW-1:0]    ep_addr,
  input  logic [AW-1:0]    end_idx,
  input  logic [DW-1:0]    load_delta,
  output logic [AW-1:0]    load_idx,
  output logic [AW-1:0]    cur_idx,
  output logic             valid
);
  logic [DW-1:0] rem;
  logic [AW-1:0] nxt_idx;

  assign nxt_idx  = (cur_idx == end_idx) ? ep_addr : cur_idx + AW'(1);
  assign load_idx = valid ? nxt_idx : ep_addr;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      valid   <= 1'b0;
      cur_idx <= '0;
      rem     <= '0;
    end else if (tick) begin
      if (!valid) begin
        if (tod >= start_at) begin
          valid   <= 1'b1;
          cur_idx <= load_idx;
          rem     <= load_delta;
        end
      end else if (rem <= DW'(1)) begin
        cur_idx <= load_idx;
        rem     <= load_delta;
      end else begin
        rem <= rem - DW'(1);
      end
    end
  end
endmodule

// File: rtl/gs_gate_merge.sv
module gs_gate_merge #(
  parameter int NT  = 8,
  parameter int NP  = 5,
  parameter int NTC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NT-1:0]     valid,
  input  logic [NP-1:0]     ports  [NT],
  input  logic [NTC-1:0]    closed [NT],
  output logic [NP*NTC-1:0] gate_closed,
  output logic              collide
);
  logic [NP*NTC-1:0] gate_n;
  logic              coll_n;

  always_comb begin
    gate_n = '0;
    coll_n = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (valid[i]) begin
        for (int p = 0; p < NP; p++) begin
          if (ports[i][p]) gate_n[p*NTC +: NTC] = gate_n[p*NTC +: NTC] | closed[i];
        end
        for (int j = i + 1; j < NT; j++) begin
          if (valid[j] && ((ports[i] & ports[j]) != '0)) coll_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_closed <= '0;
      collide     <= 1'b0;
    end else begin
      gate_closed <= gate_n;
      collide     <= coll_n;
    end
  end
endmodule

// File: rtl/gs_sched.sv
module gs_sched
  import gs_pkg::*;
#(
  parameter int NT    = 8,
  parameter int NP    = 5,
  parameter int NTC   = 8,
  parameter int DEPTH = 32,
  parameter int DW    = 20,
  parameter int TOD_W = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int TW   = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TOD_W-1:0]  tod,
  input  logic              tick,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [DW-1:0]     tbl_delta,
  input  logic [NP-1:0]     tbl_ports,
  input  logic [NTC-1:0]    tbl_closed,
  input  logic              thr_we,
  input  logic [TW-1:0]     thr_sel,
  input  logic [DW-1:0]     thr_ep_delta,
  input  logic [AW-1:0]     thr_ep_addr,
  input  logic [AW-1:0]     thr_end,
  input  logic              glob_we,
  input  logic [TOD_W-1:0]  glob_base,
  input  logic [TW-1:0]     glob_last,
  output logic [NP*NTC-1:0] gate_closed,
  output logic              sched_running,
  output logic              sched_armed,
  output logic              collide,
  output logic              load_err
);
  eng_state_t       state;
  logic             wr_ok;
  logic             tbl_bad, thr_bad;
  logic [TOD_W-1:0] base_q;
  logic [TW-1:0]    last_q;
  logic [DW-1:0]    ep_delta_q [NT];
  logic [AW-1:0]    ep_addr_q  [NT];
  logic [AW-1:0]    end_q      [NT];

  logic [DW-1:0]    s_delta  [DEPTH];
  logic [NP-1:0]    s_ports  [DEPTH];
  logic [NTC-1:0]   s_closed [DEPTH];

  logic [NT-1:0]    thr_valid;
  logic [NT-1:0]    thr_en;
  logic [AW-1:0]    ld_idx   [NT];
  logic [AW-1:0]    cur_idx  [NT];
  logic [DW-1:0]    ld_delta [NT];
  logic [NP-1:0]    t_ports  [NT];
  logic [NTC-1:0]   t_closed [NT];

  assign wr_ok   = (state == ST_STOP);
  assign thr_bad = thr_we && wr_ok && (thr_ep_delta == '0);

  // engine control: stop wins over everything
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_STOP;
    end else if (stop_cmd) begin
      state <= ST_STOP;
    end else begin
      case (state)
        ST_STOP:  if (start_cmd) state <= ST_ARMED;
        ST_ARMED: if (tod >= base_q) state <= ST_RUN;
        default:  state <= state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      last_q <= '0;
      for (int i = 0; i < NT; i++) begin
        ep_delta_q[i] <= '0;
        ep_addr_q[i]  <= '0;
        end_q[i]      <= '0;
      end
    end else begin
      if (glob_we && wr_ok) begin
        base_q <= glob_base;
        last_q <= glob_last;
      end
      if (thr_we && wr_ok && (thr_ep_delta != '0)) begin
        ep_delta_q[thr_sel] <= thr_ep_delta;
        ep_addr_q[thr_sel]  <= thr_ep_addr;
        end_q[thr_sel]      <= thr_end;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) load_err <= 1'b0;
    else if (tbl_bad || thr_bad) load_err <= 1'b1;
  end

  gs_slot_table #(
    .DEPTH(DEPTH), .NP(NP), .NTC(NTC), .DW(DW), .LIM_LOG2(SLOT_LIM_LOG2)
  ) i_table (
    .clk      (clk),
    .we       (tbl_we && wr_ok),
    .waddr    (tbl_addr),
    .wdelta   (tbl_delta),
    .wports   (tbl_ports),
    .wclosed  (tbl_closed),
    .wr_bad   (tbl_bad),
    .delta_q  (s_delta),
    .ports_q  (s_ports),
    .closed_q (s_closed)
  );

  for (genvar g = 0; g < NT; g++) begin : g_thr
    logic [TOD_W-1:0] start_at;

    assign start_at    = base_q + TOD_W'(ep_delta_q[g]);
    assign thr_en[g]   = (state != ST_STOP) && (TW'(g) <= last_q);
    assign ld_delta[g] = s_delta[ld_idx[g]];
    assign t_ports[g]  = s_ports[cur_idx[g]];
    assign t_closed[g] = s_closed[cur_idx[g]];

    gs_thread #(.DEPTH(DEPTH), .DW(DW), .TOD_W(TOD_W)) i_thread (
      .clk        (clk),
      .rst        (rst),
      .en         (thr_en[g]),
      .tick       (tick),
      .tod        (tod),
      .start_at   (start_at),
      .ep_addr    (ep_addr_q[g]),
      .end_idx    (end_q[g]),
      .load_delta (ld_delta[g]),
      .load_idx   (ld_idx[g]),
      .cur_idx    (cur_idx[g]),
      .valid      (thr_valid[g])
    );
  end

  gs_gate_merge #(.NT(NT), .NP(NP), .NTC(NTC)) i_merge (
    .clk         (clk),
    .rst         (rst),
    .valid       (thr_valid),
    .ports       (t_ports),
    .closed      (t_closed),
    .gate_closed (gate_closed),
    .collide     (collide)
  );

  assign sched_running = (state == ST_RUN);
  assign sched_armed   = (state == ST_ARMED);
endmodule

// File: rtl/gs_sched_chk.sv
module gs_sched_chk #(
  parameter int NT  = 8,
  parameter int NP  = 5,
  parameter int NTC = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_cmd,
  input logic [NP*NTC-1:0] gate_closed,
  input logic              sched_running,
  input logic              sched_armed,
  input logic              collide,
  input logic              load_err,
  input logic [NT-1:0]     thr_valid
);
  p_reset_idle_r1: assert property (@(posedge clk)
    $fell(rst) |-> (gate_closed == '0 && !sched_running && !sched_armed && !collide && !load_err));

  p_run_after_arm_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sched_running) |-> $past(sched_armed));

  p_stop_status_r8: assert property (@(posedge clk) disable iff (rst)
    stop_cmd |=> (!sched_running && !sched_armed));

  p_idle_gates_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(sched_running) && !$past(sched_armed) &&
     !$past(sched_running, 2) && !$past(sched_armed, 2)) |-> (gate_closed == '0 && !collide));

  p_collide_two_r7: assert property (@(posedge clk) disable iff (rst)
    collide |-> ($countones($past(thr_valid)) >= 2));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    load_err |=> load_err);
endmodule

bind gs_sched gs_sched_chk #(.NT(NT), .NP(NP), .NTC(NTC)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .stop_cmd      (stop_cmd),
  .gate_closed   (gate_closed),
  .sched_running (sched_running),
  .sched_armed   (sched_armed),
  .collide       (collide),
  .load_err      (load_err),
  .thr_valid     (thr_valid)
);

// File: tb/test_gs_sched.sv
module test_gs_sched;
  localparam int NT = 8, NP = 5, NTC = 8, DEPTH = 32, DW = 20, TOD_W = 32;
  localparam int AW = 5, TW = 3, GW = NP * NTC;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [TOD_W-1:0] tod;
  logic             tick = 1'b1;
  logic             start_cmd = 1'b0, stop_cmd = 1'b0;
  logic             tbl_we = 1'b0;
  logic [AW-1:0]    tbl_addr = '0;
  logic [DW-1:0]    tbl_delta = '0;
  logic [NP-1:0]    tbl_ports = '0;
  logic [NTC-1:0]   tbl_closed = '0;
  logic             thr_we = 1'b0;
  logic [TW-1:0]    thr_sel = '0;
  logic [DW-1:0]    thr_ep_delta = '0;
  logic [AW-1:0]    thr_ep_addr = '0, thr_end = '0;
  logic             glob_we = 1'b0;
  logic [TOD_W-1:0] glob_base = '0;
  logic [TW-1:0]    glob_last = '0;
  logic [GW-1:0]    gate_closed;
  logic             sched_running, sched_armed, collide, load_err;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit chk_on = 1'b0;

  // expected configuration, kept by the bench
  int            m_delta [DEPTH];
  logic [NP-1:0] m_port  [DEPTH];
  logic [NTC-1:0] m_closed [DEPTH];
  int            m_ep [NT], m_addr [NT], m_end [NT];
  int            m_last;
  longint        m_base;

  typedef struct { logic [GW-1:0] g; logic c; logic r; } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tod = TOD_W'(cyc);

  gs_sched #(.NT(NT), .NP(NP), .NTC(NTC), .DEPTH(DEPTH), .DW(DW), .TOD_W(TOD_W)) i_gs_sched (
    .clk(clk), .rst(rst), .tod(tod), .tick(tick), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_delta(tbl_delta), .tbl_ports(tbl_ports),
    .tbl_closed(tbl_closed), .thr_we(thr_we), .thr_sel(thr_sel), .thr_ep_delta(thr_ep_delta),
    .thr_ep_addr(thr_ep_addr), .thr_end(thr_end), .glob_we(glob_we), .glob_base(glob_base),
    .glob_last(glob_last), .gate_closed(gate_closed), .sched_running(sched_running),
    .sched_armed(sched_armed), .collide(collide), .load_err(load_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // time-based model: state of every thread after edge e-1 drives the outputs after edge e
  task automatic push_expect(input longint e);
    exp_t x;
    logic [NP-1:0]  vp [NT];
    logic [NTC-1:0] vc [NT];
    bit             vv [NT];
    x.g = '0;
    x.c = 1'b0;
    x.r = (e >= m_base);
    for (int i = 0; i < NT; i++) begin
      longint st;
      vv[i] = 1'b0;
      vp[i] = '0;
      vc[i] = '0;
      st = m_base + m_ep[i];
      if (i <= m_last && (e - 1) >= st) begin
        longint len, o;
        int s;
        len = 0;
        for (int k = m_addr[i]; k <= m_end[i]; k++) len += m_delta[k];
        o = (e - 1 - st) % len;
        s = m_addr[i];
        while (o >= m_delta[s]) begin
          o -= m_delta[s];
          s++;
        end
        vv[i] = 1'b1;
        vp[i] = m_port[s];
        vc[i] = m_closed[s];
      end
    end
    for (int i = 0; i < NT; i++) begin
      if (vv[i]) begin
        for (int p = 0; p < NP; p++)
          if (vp[i][p]) x.g[p*NTC +: NTC] = x.g[p*NTC +: NTC] | vc[i];
        for (int j = i + 1; j < NT; j++)
          if (vv[j] && ((vp[i] & vp[j]) != '0)) x.c = 1'b1;
      end
    end
    sbq.push_back(x);
  endtask

  task automatic pop_compare();
    exp_t x;
    x = sbq.pop_front();
    check(gate_closed == x.g, "R3 R4 R5 R6", "gate vector", longint'(gate_closed), longint'(x.g));
    check(collide == x.c, "R7", "collide", longint'(collide), longint'(x.c));
    check(sched_running == x.r, "R2", "running", longint'(sched_running), longint'(x.r));
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      push_expect(longint'(cyc) - 1);
      pop_compare();
    end
  end

  task automatic wr_slot(input int a, input int d, input logic [NP-1:0] p, input logic [NTC-1:0] c,
                         input bit track);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = AW'(a); tbl_delta = DW'(d); tbl_ports = p; tbl_closed = c;
    @(negedge clk);
    tbl_we = 1'b0;
    if (track) begin
      m_delta[a] = d; m_port[a] = p; m_closed[a] = c;
    end
  endtask

  task automatic wr_thr(input int t, input int ep, input int a, input int e, input bit track);
    @(negedge clk);
    thr_we = 1'b1; thr_sel = TW'(t); thr_ep_delta = DW'(ep); thr_ep_addr = AW'(a); thr_end = AW'(e);
    @(negedge clk);
    thr_we = 1'b0;
    if (track) begin
      m_ep[t] = ep; m_addr[t] = a; m_end[t] = e;
    end
  endtask

  task automatic start_run(input int last);
    @(negedge clk);
    m_base = longint'(cyc) + 10;
    m_last = last;
    glob_we = 1'b1; glob_base = TOD_W'(m_base); glob_last = TW'(last);
    start_cmd = 1'b1;
    @(negedge clk);
    glob_we = 1'b0; start_cmd = 1'b0;
    check(sched_armed == 1'b1 && sched_running == 1'b0, "R2", "armed after start",
          longint'({sched_armed, sched_running}), 64'h2);
    chk_on = 1'b1;
  endtask

  task automatic stop_run();
    @(negedge clk);
    chk_on = 1'b0;
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
    check(!sched_running && !sched_armed, "R8", "status after stop",
          longint'({sched_armed, sched_running}), 0);
    @(negedge clk);
    @(negedge clk);
    check(gate_closed == '0, "R8", "gates open after stop", longint'(gate_closed), 0);
    check(collide == 1'b0, "R8", "collide after stop", longint'(collide), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NT; i++) begin m_ep[i] = 1; m_addr[i] = 0; m_end[i] = 0; end
    m_last = 0;
    m_base = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(gate_closed == '0, "R1", "gate after reset", longint'(gate_closed), 0);
    check(!sched_running && !sched_armed, "R1", "status after reset",
          longint'({sched_armed, sched_running}), 0);
    check(!collide && !load_err, "R1", "flags after reset", longint'({collide, load_err}), 0);

    // slot table: thread 0 on port 0 (slots 0..2), thread 1 on port 1 (slots 3..4)
    wr_slot(0, 3, 5'b00001, 8'h01, 1'b1);
    wr_slot(1, 2, 5'b00001, 8'h02, 1'b1);
    wr_slot(2, 4, 5'b00001, 8'h04, 1'b1);
    wr_slot(3, 5, 5'b00010, 8'h10, 1'b1);
    wr_slot(4, 4, 5'b00010, 8'h20, 1'b1);
    wr_thr(0, 1, 0, 2, 1'b1);
    wr_thr(1, 4, 3, 4, 1'b1);
    // R6: unused threads would hit port 0 again if they ever ran
    for (int t = 2; t < NT; t++) wr_thr(t, 1, 0, 4, 1'b0);
    check(load_err == 1'b0, "R9", "no error on legal writes", longint'(load_err), 0);

    // R9: illegal writes are dropped and flagged
    wr_slot(0, 0, 5'b11111, 8'hFF, 1'b0);
    check(load_err == 1'b1, "R9", "zero slot delta flagged", longint'(load_err), 1);
    wr_slot(1, 1 << 19, 5'b11111, 8'hFF, 1'b0);
    wr_thr(0, 0, 3, 3, 1'b0);
    check(load_err == 1'b1, "R9", "error stays set", longint'(load_err), 1);

    // scenario 1: two threads on separate ports, staggered starts (R3, R4, R5, R6)
    start_run(1);
    repeat (30) @(negedge clk);
    // R10: writes during a run are ignored
    tbl_we = 1'b1; tbl_addr = '0; tbl_delta = DW'(1); tbl_ports = 5'h1F; tbl_closed = 8'hFF;
    thr_we = 1'b1; thr_sel = '0; thr_ep_delta = DW'(7); thr_ep_addr = AW'(4); thr_end = AW'(4);
    glob_we = 1'b1; glob_last = 3'd7; glob_base = '0;
    @(negedge clk);
    tbl_we = 1'b0; thr_we = 1'b0; glob_we = 1'b0;
    repeat (40) @(negedge clk);
    stop_run();

    // scenario 2: thread 1 also drives port 0 (R7 overlap and OR)
    wr_slot(3, 5, 5'b00011, 8'h10, 1'b1);
    wr_slot(4, 4, 5'b00011, 8'h20, 1'b1);
    start_run(1);
    repeat (45) @(negedge clk);
    stop_run();

    // scenario 3: only thread 0 active (R6)
    start_run(0);
    repeat (35) @(negedge clk);
    stop_run();

    finish_run();
  end
endmodule